// File: doc/BRIEF.md
# Two-Phase Soft-Start Sequencer

This block is the digital stand-in for a soft-start capacitor and the controller that steps a standby power system through bring-up. An unsigned ramp counter takes the place of the capacitor voltage. The counter is scaled so that the thresholds (precharge level, tracking start, tracking top, arming level and active hold level) are parameters in counter units. The ramp value goes to the reference clamps of the regulators. A set of per-group enables tells the rails which group tracks the ramp and which group has its undervoltage monitors armed.

Bring-up has two ramps. After power-on reset or the release of a shutdown request, the counter first precharges in one step and then climbs one count per ramp tick. During the first ramp only the standby group (the 3.3 V dual rail and the 1.8 V standby rail) tracks the ramp. When the counter reaches the arming level, the standby monitors are armed and the counter snaps back to the tracking start level. After a fixed wait, a one-cycle strobe latches the memory-voltage selection and the sleep-support option, and a second ramp brings up the remaining rails. When the second ramp ends, the counter settles at the active hold level if the system is in the active state, or at the tracking start level otherwise. A later sleep request pulls an active hold down to the start level.

All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `softstart_seq`

## Requirements
- R1: While reset is low, ramp_val is 0, every enable is 0, cfg_latch is 0, and mem_sel_3v3 and sleep_opt_q are 0. Once reset and shutdown are both released, ramp_val equals PRE_LVL (default 80) on the second rising edge.
- R2: During either ramp, ramp_val rises by exactly one on each clock edge that samples ramp_tick high. It saturates at its all-ones value and never wraps.
- R3: stby_ramp_en is high from the start of the first ramp until shutdown. main_ramp_en is high only from the start of the second ramp, and never without stby_ramp_en.
- R4: On the edge that samples ramp_val at or above ARM_LVL (default 220) during the first ramp, stby_mon_en goes high and ramp_val becomes START_LVL (default 100).
- R5: After the first arming, exactly WAIT_CYC clock cycles (default 30) elapse before cfg_latch pulses high for one cycle. The second ramp begins at START_LVL in that same cycle.
- R6: mem_sel_3v3 takes the value of msel_above_ref only at the cfg_latch strobe: 1 selects 3.3 V (sensed voltage at or above the 200 mV reference) and 0 selects 2.5 V. Changes at any other time are ignored.
- R7: sleep_opt_q takes the value of sleep_opt_in only at the cfg_latch strobe. Changes at any other time are ignored.
- R8: On the edge that ends the second ramp (ramp_val at or above ARM_LVL), main_mon_en goes high. ramp_val becomes HOLD_LVL (default 196) if active_req is high, or START_LVL if it is low.
- R9: In the hold phase, ramp_val drops to START_LVL on the edge after active_req is sampled low. It stays there even if active_req returns high.
- R10: On the edge after shutdown_req is sampled high, ramp_val is 0 and every enable is 0. Its release starts a full new cycle from precharge, including a fresh configuration latch.
- R11: Outside the two ramps, ramp_tick has no effect on ramp_val.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| shutdown_req | input | 1 | Shutdown request, high forces the ramp to zero |
| ramp_tick | input | 1 | Slow ramp-rate tick, one count per sampled high |
| active_req | input | 1 | High when the system is in the active state |
| msel_above_ref | input | 1 | Memory select sense at or above the reference (3.3 V choice) |
| sleep_opt_in | input | 1 | Sleep-support option for the 5 V dual rail |
| ramp_val | output | RAMP_W | Ramp value fed to the reference clamps |
| stby_ramp_en | output | 1 | Standby group tracks the ramp |
| main_ramp_en | output | 1 | Remaining rails track the ramp |
| stby_mon_en | output | 1 | Standby group undervoltage monitors armed |
| main_mon_en | output | 1 | Remaining rails' undervoltage monitors armed |
| cfg_latch | output | 1 | One-cycle configuration latch strobe |
| mem_sel_3v3 | output | 1 | Latched memory voltage choice, 1 = 3.3 V |
| sleep_opt_q | output | 1 | Latched sleep-support option |

## Verification
The assertions check several properties on every cycle:
- the counter never wraps;
- the main group never ramps without the standby group;
- a shutdown always clears the ramp and the monitors;
- the strobe is a single-cycle pulse;
- the latched configuration only moves at the strobe;
- the ramp stays still during the wait.

Some behaviours can only be shown by the bench's scenarios, because they depend on long stretches of time:
- the exact length of the wait;
- the snap-back levels at each arming;
- the two different hold levels after the second ramp;
- the full restart after a shutdown with a new configuration.

A behavioural model compares every output on every clock across different tick rates.

// File: rtl/ss_pkg.sv
package ss_pkg;
  typedef enum logic [2:0] {
    PH_OFF   = 3'd0,
    PH_PRE   = 3'd1,
    PH_RAMP1 = 3'd2,
    PH_WAIT  = 3'd3,
    PH_RAMP2 = 3'd4,
    PH_HOLD  = 3'd5
  } ss_phase_e;
endpackage

// File: rtl/ss_ramp_counter.sv
module ss_ramp_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] val
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 val <= '0;
    else if (clr)               val <= '0;
    else if (load)              val <= load_val;
    else if (step && val != TOP) val <= val + 1'b1;
  end

  // R2: a plain step never lowers or wraps the value
  assert_ramp_no_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && !load) |=> (val >= $past(val)) && (val != '0));
endmodule

// File: rtl/ss_wait_timer.sv
module ss_wait_timer #(
  parameter int CYC = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic done
);
  localparam int CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (en && cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign done = en && (cnt == LAST);

  // R5: the wait advances by one per enabled cycle
  assert_wait_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && !done) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/ss_cfg_capture.sv
module ss_cfg_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic msel_in,
  input  logic opt_in,
  output logic msel_q,
  output logic opt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msel_q <= 1'b0;
      opt_q  <= 1'b0;
    end else if (strobe) begin
      msel_q <= msel_in;
      opt_q  <= opt_in;
    end
  end

  // R6: memory choice only moves at the strobe
  assert_msel_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(msel_q));
  // R7: sleep option only moves at the strobe
  assert_opt_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(opt_q));
endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
  import ss_pkg::*;
#(
  parameter int RAMP_W    = 8,
  parameter int PRE_LVL   = 80,
  parameter int START_LVL = 100,
  parameter int ARM_LVL   = 220,
  parameter int HOLD_LVL  = 196,
  parameter int WAIT_CYC  = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shutdown_req,
  input  logic              ramp_tick,
  input  logic              active_req,
  input  logic              msel_above_ref,
  input  logic              sleep_opt_in,
  output logic [RAMP_W-1:0] ramp_val,
  output logic              stby_ramp_en,
  output logic              main_ramp_en,
  output logic              stby_mon_en,
  output logic              main_mon_en,
  output logic              cfg_latch,
  output logic              mem_sel_3v3,
  output logic              sleep_opt_q
);
  localparam logic [RAMP_W-1:0] PRE_V   = RAMP_W'(PRE_LVL);
  localparam logic [RAMP_W-1:0] START_V = RAMP_W'(START_LVL);
  localparam logic [RAMP_W-1:0] ARM_V   = RAMP_W'(ARM_LVL);
  localparam logic [RAMP_W-1:0] HOLD_V  = RAMP_W'(HOLD_LVL);

  ss_phase_e         phase;
  logic              arm_hit;
  logic              ld;
  logic [RAMP_W-1:0] ld_val;
  logic              stp;
  logic              wait_done;
  logic              capture;

  assign arm_hit = (ramp_val >= ARM_V);
  assign capture = (phase == PH_WAIT) && wait_done && !shutdown_req;

  always_comb begin
    ld     = 1'b0;
    ld_val = START_V;
    stp    = 1'b0;
    unique case (phase)
      PH_PRE: begin
        ld     = 1'b1;
        ld_val = PRE_V;
      end
      PH_RAMP1, PH_RAMP2: begin
        if (arm_hit) begin
          ld     = 1'b1;
          ld_val = (phase == PH_RAMP2 && active_req) ? HOLD_V : START_V;
        end else begin
          stp = ramp_tick;
        end
      end
      PH_HOLD: begin
        ld     = !active_req && (ramp_val != START_V);
        ld_val = START_V;
      end
      default: ;
    endcase
  end

  ss_ramp_counter #(.W(RAMP_W)) u_ramp (
    .clk(clk), .rst_n(rst_n), .clr(shutdown_req),
    .load(ld), .load_val(ld_val), .step(stp), .val(ramp_val)
  );

  ss_wait_timer #(.CYC(WAIT_CYC)) u_wait (
    .clk(clk), .rst_n(rst_n), .clr(phase != PH_WAIT),
    .en(phase == PH_WAIT), .done(wait_done)
  );

  ss_cfg_capture u_cfg (
    .clk(clk), .rst_n(rst_n), .strobe(capture),
    .msel_in(msel_above_ref), .opt_in(sleep_opt_in),
    .msel_q(mem_sel_3v3), .opt_q(sleep_opt_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_OFF;
      stby_mon_en <= 1'b0;
      main_mon_en <= 1'b0;
      cfg_latch   <= 1'b0;
    end else if (shutdown_req) begin
      phase       <= PH_OFF;
      stby_mon_en <= 1'b0;
      main_mon_en <= 1'b0;
      cfg_latch   <= 1'b0;
    end else begin
      cfg_latch <= capture;
      unique case (phase)
        PH_OFF:   phase <= PH_PRE;
        PH_PRE:   phase <= PH_RAMP1;
        PH_RAMP1: if (arm_hit) begin
                    phase       <= PH_WAIT;
                    stby_mon_en <= 1'b1;
                  end
        PH_WAIT:  if (wait_done) phase <= PH_RAMP2;
        PH_RAMP2: if (arm_hit) begin
                    phase       <= PH_HOLD;
                    main_mon_en <= 1'b1;
                  end
        default:  phase <= phase;
      endcase
    end
  end

  assign stby_ramp_en = (phase == PH_RAMP1) || (phase == PH_WAIT) ||
                        (phase == PH_RAMP2) || (phase == PH_HOLD);
  assign main_ramp_en = (phase == PH_RAMP2) || (phase == PH_HOLD);

  // R3: remaining rails never ramp without the standby group
  assert_main_after_stby_R3: assert property (@(posedge clk) disable iff (!rst_n)
    main_ramp_en |-> stby_ramp_en && stby_mon_en);
  // R4: first arming snaps the ramp back and arms standby monitors
  assert_first_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RAMP1 && arm_hit && !shutdown_req) |=> stby_mon_en && ramp_val == START_V);
  // R5: the strobe lasts one cycle
  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_latch |=> !cfg_latch);
  // R8: second arming lands on one of the two hold levels
  assert_hold_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_mon_en) |-> (ramp_val == HOLD_V || ramp_val == START_V));
  // R10: shutdown clears ramp and monitors
  assert_shutdown_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |=> ramp_val == '0 && !stby_mon_en && !main_mon_en && !stby_ramp_en);
  // R11: the ramp does not move during the wait
  assert_wait_still_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WAIT && !shutdown_req) |=> $stable(ramp_val));
endmodule

// File: tb/tb_softstart_seq.sv
module tb_softstart_seq;
  localparam int CLK_PERIOD = 10;
  localparam int PRE = 80, START = 100, ARM = 220, HOLD = 196, WAITC = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shutdown_req = 1'b0, ramp_tick = 1'b0, active_req = 1'b1;
  logic msel_above_ref = 1'b0, sleep_opt_in = 1'b0;
  logic [7:0] ramp_val;
  logic stby_ramp_en, main_ramp_en, stby_mon_en, main_mon_en;
  logic cfg_latch, mem_sel_3v3, sleep_opt_q;

  int checks = 0, fails = 0, tick_div = 1, tick_ctr = 0, cyc_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  softstart_seq dut (
    .clk(clk), .rst_n(rst_n), .shutdown_req(shutdown_req), .ramp_tick(ramp_tick),
    .active_req(active_req), .msel_above_ref(msel_above_ref), .sleep_opt_in(sleep_opt_in),
    .ramp_val(ramp_val), .stby_ramp_en(stby_ramp_en), .main_ramp_en(main_ramp_en),
    .stby_mon_en(stby_mon_en), .main_mon_en(main_mon_en), .cfg_latch(cfg_latch),
    .mem_sel_3v3(mem_sel_3v3), .sleep_opt_q(sleep_opt_q)
  );

  // behavioural reference: 0 off,1 precharge,2 ramp1,3 wait,4 ramp2,5 hold
  int m_ph = 0, m_ramp = 0, m_wait = 0;
  bit m_smon = 0, m_mmon = 0, m_strb = 0, m_msel = 0, m_opt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_ramp = 0; m_wait = 0; m_smon = 0; m_mmon = 0;
      m_strb = 0; m_msel = 0; m_opt = 0;
    end else if (shutdown_req) begin
      m_ph = 0; m_ramp = 0; m_smon = 0; m_mmon = 0; m_strb = 0;
    end else begin
      m_strb = 0;
      case (m_ph)
        0: m_ph = 1;
        1: begin m_ramp = PRE; m_ph = 2; end
        2: if (m_ramp >= ARM) begin m_ramp = START; m_smon = 1; m_ph = 3; m_wait = 0; end
           else if (ramp_tick && m_ramp < 255) m_ramp++;
        3: if (m_wait == WAITC-1) begin
             m_ph = 4; m_strb = 1; m_msel = msel_above_ref; m_opt = sleep_opt_in;
           end else m_wait++;
        4: if (m_ramp >= ARM) begin
             m_mmon = 1; m_ph = 5; m_ramp = active_req ? HOLD : START;
           end else if (ramp_tick && m_ramp < 255) m_ramp++;
        5: if (!active_req) m_ramp = START;
        default: ;
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc_cnt);
    end
  endtask

  task automatic compare_all();
    chk(ramp_val == m_ramp[7:0], "R2 ramp_val", ramp_val, m_ramp);
    chk(stby_ramp_en == (m_ph >= 2), "R3 stby_ramp_en", stby_ramp_en, m_ph >= 2);
    chk(main_ramp_en == (m_ph >= 4), "R3 main_ramp_en", main_ramp_en, m_ph >= 4);
    chk(stby_mon_en == m_smon, "R4 stby_mon_en", stby_mon_en, m_smon);
    chk(cfg_latch == m_strb, "R5 cfg_latch", cfg_latch, m_strb);
    chk(mem_sel_3v3 == m_msel, "R6 mem_sel_3v3", mem_sel_3v3, m_msel);
    chk(sleep_opt_q == m_opt, "R7 sleep_opt_q", sleep_opt_q, m_opt);
    chk(main_mon_en == m_mmon, "R8 main_mon_en", main_mon_en, m_mmon);
  endtask

  // one clock: sample at the falling edge, then set the tick for the next edge
  task automatic cyc();
    @(negedge clk);
    cyc_cnt++;
    compare_all();
    tick_ctr++;
    ramp_tick = (tick_ctr % tick_div) == 0;
  endtask

  task automatic run_until_main_mon();
    for (int i = 0; i < 5000 && !main_mon_en; i++) cyc();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int strobes, rv;
    msel_above_ref = 1'b1; sleep_opt_in = 1'b1; active_req = 1'b1;
    repeat (3) cyc();
    // R1: reset state
    chk(ramp_val == 0 && !stby_ramp_en && !main_ramp_en && !cfg_latch, "R1 reset outputs", ramp_val, 0);
    chk(!mem_sel_3v3 && !sleep_opt_q && !stby_mon_en && !main_mon_en, "R1 reset latches", mem_sel_3v3, 0);
    rst_n = 1'b1;
    cyc(); cyc();
    chk(ramp_val == PRE, "R1 precharge level", ramp_val, PRE);

    // first ramp and arming
    for (int i = 0; i < 2000 && !stby_mon_en; i++) cyc();
    chk(ramp_val == START, "R4 snap to start", ramp_val, START);
    // R5: count cycles until the strobe
    strobes = 0;
    for (int i = 0; i < 200 && !cfg_latch; i++) begin cyc(); strobes++; end
    chk(strobes == WAITC, "R5 wait length", strobes, WAITC);
    chk(ramp_val == START && main_ramp_en, "R5 second ramp start", ramp_val, START);
    msel_above_ref = 1'b0; sleep_opt_in = 1'b0;
    cyc();
    chk(!cfg_latch, "R5 strobe one cycle", cfg_latch, 0);
    run_until_main_mon();
    chk(ramp_val == HOLD, "R8 active hold level", ramp_val, HOLD);
    chk(mem_sel_3v3 == 1'b1, "R6 held 3.3V choice", mem_sel_3v3, 1);
    chk(sleep_opt_q == 1'b1, "R7 held option", sleep_opt_q, 1);

    // R11: ticks in hold have no effect
    tick_div = 1;
    repeat (10) cyc();
    chk(ramp_val == HOLD, "R11 hold ignores ticks", ramp_val, HOLD);

    // R9: sleep request in hold
    active_req = 1'b0;
    cyc(); cyc();
    chk(ramp_val == START, "R9 sleep drop", ramp_val, START);
    active_req = 1'b1;
    repeat (5) cyc();
    chk(ramp_val == START, "R9 stays after re-activate", ramp_val, START);

    // R10: shutdown in the middle of a new cycle
    shutdown_req = 1'b1;
    cyc(); cyc();
    chk(ramp_val == 0 && !stby_mon_en && !main_mon_en, "R10 shutdown clear", ramp_val, 0);
    msel_above_ref = 1'b0; sleep_opt_in = 1'b0; active_req = 1'b0; tick_div = 3;
    shutdown_req = 1'b0;
    cyc(); cyc();
    chk(ramp_val == PRE, "R10 restart precharge", ramp_val, PRE);
    for (int i = 0; i < 2000 && !stby_mon_en; i++) cyc();
    rv = ramp_val;
    // R11: ticks during wait ignored
    repeat (10) cyc();
    chk(ramp_val == rv, "R11 wait ignores ticks", ramp_val, rv);
    // abort mid second ramp once, then finish a full cycle
    for (int i = 0; i < 200 && !main_ramp_en; i++) cyc();
    repeat (20) cyc();
    shutdown_req = 1'b1;
    cyc();
    shutdown_req = 1'b0;
    cyc();
    chk(ramp_val == 0 && !stby_ramp_en, "R10 abort second ramp", ramp_val, 0);
    run_until_main_mon();
    chk(ramp_val == START, "R8 sleep hold level", ramp_val, START);
    chk(mem_sel_3v3 == 1'b0, "R6 relatched 2.5V choice", mem_sel_3v3, 0);
    chk(sleep_opt_q == 1'b0, "R7 relatched option", sleep_opt_q, 0);
    repeat (5) cyc();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule